// File: doc/BRIEF.md
# Rank Sliding-Attack Generator

This block takes a 64-square board held as eight 8-bit rank lanes and returns, for every sliding piece on it, the squares that piece reaches along its own rank. It returns one set for attacks toward higher bit indices (east), one set for attacks toward lower bit indices (west), and their union. All sliders are handled at once. There is no per-square ray walk. Each lane forms the attack set as occupancy XOR (occupancy minus twice the sliders), and the subtraction is confined to its lane. The west set reuses the same lane logic. Each byte of the inputs is bit-reversed on the way in, and each byte of the result is bit-reversed on the way out.

The slider set comes from one of two sources. It can be given directly as a 64-bit set. It can also be derived from a board of four bit-planes that gives each square a 4-bit code, where any nonzero code marks a slider. Results are registered and appear one cycle after an accepted input, together with a valid flag.

Top module: `rank_slide_attacks`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, out_valid is 0 and att_east, att_west and att_all are all zero.
- R2: out_valid is high in the cycle after each rising clock edge at which in_valid was high, and low after each edge at which in_valid was low.
- R3: Within each rank lane, where bit 0 is the a-file square and bit 7 is the h-file square, bit q of att_east is set exactly when some slider sits at a lower index p in the same lane and every square strictly between p and q is empty. The first occupied square east of the slider is included. No square beyond it is included.
- R4: att_west follows the same rule mirrored: the slider sits at a higher index p and the ray runs toward bit 0.
- R5: No ray and no borrow crosses a rank boundary. An empty lane, or a lane without sliders, yields zero attacks, whatever the neighbouring lanes hold. A slider on the a-file square of one lane leaves the lane below it unaffected.
- R6: A slider square counts as occupied even when its bit is clear in occ_in. Such a square therefore blocks rays from other sliders.
- R7: att_all equals att_east OR att_west for the same accepted input.
- R8: When src_sel is 1, square q is a slider exactly when planes_in[4q+3:4q] is nonzero, and slide_in is ignored. When src_sel is 0, slide_in is the slider set and planes_in is ignored.
- R9: At a clock edge with in_valid low, att_east, att_west and att_all keep their previous values, whatever the data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the data inputs at this edge |
| src_sel | input | 1 | 0: use slide_in as the slider set; 1: derive it from planes_in |
| occ_in | input | 64 | Occupancy set, one byte per rank, bit 0 of a byte is the a-file |
| slide_in | input | 64 | Slider set, same layout as occ_in |
| planes_in | input | 256 | Four-bit code per square, square q at bits 4q+3..4q |
| out_valid | output | 1 | Registered results are from an input accepted last edge |
| att_east | output | 64 | Squares attacked toward higher bit index |
| att_west | output | 64 | Squares attacked toward lower bit index |
| att_all | output | 64 | Union of east and west attacks |

## Verification
The case hardest to reach from the ports is a borrow leaking between lanes. It appears only when one lane's subtraction underflows, for example a lone slider on its a-file with nothing else in the lane, while the next lane holds a pattern that a stray borrow would visibly change. To reach it, the stimulus sweeps all 65,536 occupancy and slider byte pairs. A different byte-wise scramble of the same pair goes into each of the eight lanes, so every lane underflows while its neighbours carry unrelated data. The expected sets come from a square-by-square ray walk, which shares no arithmetic with the design. Plane-derived sliders come from a pseudo-random sweep of sparse four-plane boards.

// File: rtl/rank_attack_pkg.sv
package rank_attack_pkg;

  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_PLANES = 1'b1
  } slide_src_e;

  typedef enum logic {
    DIR_EAST = 1'b0,
    DIR_WEST = 1'b1
  } ray_dir_e;

endpackage

// File: rtl/slider_source.sv
module slider_source #(
  parameter int unsigned SQUARES = 64,
  parameter int unsigned NIB_W   = 4
) (
  input  logic                       src_sel,
  input  logic [SQUARES-1:0]         slide_in,
  input  logic [SQUARES*NIB_W-1:0]   planes_in,
  output logic [SQUARES-1:0]         sliders
);
  import rank_attack_pkg::*;

  logic [SQUARES-1:0] from_planes;

  // any nonzero square code marks a slider
  for (genvar q = 0; q < SQUARES; q++) begin : g_sq
    assign from_planes[q] = |planes_in[q*NIB_W +: NIB_W];
  end

  assign sliders = (slide_src_e'(src_sel) == SRC_PLANES) ? from_planes : slide_in;

endmodule

// File: rtl/lane_east_sub.sv
module lane_east_sub #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] occ,
  input  logic [LANE_W-1:0] sld,
  output logic [LANE_W-1:0] east
);

  // occupied = occ | sld; east = occupied ^ ((occupied ^ sld) - sld)
  function automatic logic [LANE_W-1:0] sub_east(
    input logic [LANE_W-1:0] o_raw,
    input logic [LANE_W-1:0] s
  );
    logic [LANE_W-1:0] o;
    logic [LANE_W-1:0] t;
    logic [LANE_W-1:0] d;
    o = o_raw | s;
    t = o ^ s;
    d = t - s;   // lane-wide subtractor, borrow dies at the lane edge
    return o ^ d;
  endfunction

  assign east = sub_east(occ, sld);

  // lowest slider and everything below it can never be attacked eastward
  logic [LANE_W-1:0] low_slider;
  logic [LANE_W-1:0] shadow_mask;
  assign low_slider  = sld & (~sld + 1'b1);
  assign shadow_mask = low_slider | (low_slider - 1'b1);

  assert_shadow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sld != '0) |-> ((east & shadow_mask) == '0));

  assert_no_slider_no_ray_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sld == '0) |-> (east == '0));

endmodule

// File: rtl/ray_dir_unit.sv
module ray_dir_unit #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  parameter bit          MIRROR = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANE_W*LANES-1:0]  occ,
  input  logic [LANE_W*LANES-1:0]  sld,
  output logic [LANE_W*LANES-1:0]  rays
);
  localparam int unsigned BOARD_W = LANE_W * LANES;

  function automatic logic [BOARD_W-1:0] flip_lanes(input logic [BOARD_W-1:0] x);
    logic [BOARD_W-1:0] y;
    for (int l = 0; l < LANES; l++)
      for (int b = 0; b < LANE_W; b++)
        y[l*LANE_W + b] = x[l*LANE_W + (LANE_W-1-b)];
    return y;
  endfunction

  logic [BOARD_W-1:0] occ_l;
  logic [BOARD_W-1:0] sld_l;
  logic [BOARD_W-1:0] ray_l;

  if (MIRROR) begin : g_mirror
    assign occ_l = flip_lanes(occ);
    assign sld_l = flip_lanes(sld);
    assign rays  = flip_lanes(ray_l);
  end else begin : g_direct
    assign occ_l = occ;
    assign sld_l = sld;
    assign rays  = ray_l;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_east_sub #(.LANE_W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .occ  (occ_l[l*LANE_W +: LANE_W]),
      .sld  (sld_l[l*LANE_W +: LANE_W]),
      .east (ray_l[l*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/rank_slide_attacks.sv
module rank_slide_attacks #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic                             src_sel,
  input  logic [LANE_W*LANES-1:0]          occ_in,
  input  logic [LANE_W*LANES-1:0]          slide_in,
  input  logic [LANE_W*LANES*NIB_W-1:0]    planes_in,
  output logic                             out_valid,
  output logic [LANE_W*LANES-1:0]          att_east,
  output logic [LANE_W*LANES-1:0]          att_west,
  output logic [LANE_W*LANES-1:0]          att_all
);
  import rank_attack_pkg::*;

  localparam int unsigned BOARD_W = LANE_W * LANES;

  function automatic logic [BOARD_W-1:0] file_mask(input int unsigned bitpos);
    logic [BOARD_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++) m[l*LANE_W + bitpos] = 1'b1;
    return m;
  endfunction

  localparam logic [BOARD_W-1:0] LOW_FILE  = file_mask(0);
  localparam logic [BOARD_W-1:0] HIGH_FILE = file_mask(LANE_W-1);

  logic [BOARD_W-1:0] sliders;
  logic [BOARD_W-1:0] east_c;
  logic [BOARD_W-1:0] west_c;

  slider_source #(.SQUARES(BOARD_W), .NIB_W(NIB_W)) u_src (
    .src_sel  (src_sel),
    .slide_in (slide_in),
    .planes_in(planes_in),
    .sliders  (sliders)
  );

  ray_dir_unit #(.LANE_W(LANE_W), .LANES(LANES), .MIRROR(DIR_EAST == DIR_WEST)) u_east (
    .clk  (clk),
    .rst_n(rst_n),
    .occ  (occ_in),
    .sld  (sliders),
    .rays (east_c)
  );

  ray_dir_unit #(.LANE_W(LANE_W), .LANES(LANES), .MIRROR(1'b1)) u_west (
    .clk  (clk),
    .rst_n(rst_n),
    .occ  (occ_in),
    .sld  (sliders),
    .rays (west_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      att_east  <= '0;
      att_west  <= '0;
      att_all   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        att_east <= east_c;
        att_west <= west_c;
        att_all  <= east_c | west_c;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(att_east) && $stable(att_west) && $stable(att_all)));

  assert_union_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (att_all == (att_east | att_west)));

  assert_east_low_file_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (att_east & LOW_FILE) == '0);

  assert_west_high_file_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (att_west & HIGH_FILE) == '0);

endmodule

// File: tb/sim_rank_slide_attacks.sv
module sim_rank_slide_attacks;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         src_sel = 1'b0;
  logic [63:0]  occ_in = '0;
  logic [63:0]  slide_in = '0;
  logic [255:0] planes_in = '0;
  logic         out_valid;
  logic [63:0]  att_east, att_west, att_all;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  rank_slide_attacks u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_sel(src_sel),
    .occ_in(occ_in), .slide_in(slide_in), .planes_in(planes_in),
    .out_valid(out_valid), .att_east(att_east), .att_west(att_west), .att_all(att_all)
  );

  // square-by-square ray walk, east (dir=0) or west (dir=1)
  function automatic logic [63:0] walk(input logic [63:0] occ, input logic [63:0] sld, input bit dir);
    logic [63:0] r;
    logic [63:0] full;
    r = '0;
    full = occ | sld;
    for (int l = 0; l < 8; l++)
      for (int p = 0; p < 8; p++)
        if (sld[l*8+p]) begin
          if (!dir) begin
            for (int q = p + 1; q < 8; q++) begin
              r[l*8+q] = 1'b1;
              if (full[l*8+q]) break;
            end
          end else begin
            for (int q = p - 1; q >= 0; q--) begin
              r[l*8+q] = 1'b1;
              if (full[l*8+q]) break;
            end
          end
        end
    return r;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [63:0] e, input logic [63:0] w);
    checks++;
    if (out_valid !== 1'b1 || att_east !== e || att_west !== w || att_all !== (e | w)) begin
      failures++;
      $display("FAIL %s actual v=%b e=%h w=%h a=%h expected v=1 e=%h w=%h a=%h",
               req, out_valid, att_east, att_west, att_all, e, w, e | w);
    end
  endtask

  function automatic logic [63:0] spread(input logic [7:0] base, input int salt);
    logic [63:0] v;
    for (int l = 0; l < 8; l++) v[l*8 +: 8] = base ^ 8'(l * salt);
    return v;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] pe, pw, ho, hs, seed, s, o;
    bit pend;
    // R1: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || att_east !== '0 || att_west !== '0 || att_all !== '0) begin
      failures++;
      $display("FAIL R1 actual v=%b e=%h w=%h expected 0", out_valid, att_east, att_west);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || att_all !== '0) begin
      failures++;
      $display("FAIL R1 actual v=%b a=%h expected v=0 a=0", out_valid, att_all);
    end

    // R3 R4 R5 R6 R7: exhaustive lane sweep, scrambled per lane (occ may omit sliders: R6)
    pend = 1'b0;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        if (pend) check_out("R3/R4/R5/R6/R7 sweep", pe, pw);
        o = spread(8'(i), 8'h35);
        s = spread(8'(j), 8'h5b);
        occ_in = o; slide_in = s; src_sel = 1'b0; in_valid = 1'b1;
        planes_in = {4{o}};   // ignored when src_sel=0 (R8)
        pe = walk(o, s, 1'b0); pw = walk(o, s, 1'b1); pend = 1'b1;
        @(negedge clk);
      end
    end
    check_out("R3/R4/R5 sweep", pe, pw);

    // R2: valid drops; R9: outputs hold with new data while idle
    in_valid = 1'b0;
    occ_in = 64'h0; slide_in = 64'h0100_0000_0000_0001;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R2 actual=%b expected=0", out_valid); end
    check64("R9 east hold", att_east, pe);
    check64("R9 west hold", att_west, pw);
    @(negedge clk);
    check64("R9 all hold", att_all, pe | pw);

    // R5: lone a-file slider underflows its lane only
    in_valid = 1'b1;
    occ_in = 64'h0; slide_in = 64'h0000_0000_0000_0100;
    @(negedge clk);
    check_out("R5 borrow boundary", 64'h0000_0000_0000_FE00, 64'h0);
    checks++;
    if (out_valid !== 1'b1) begin failures++; $display("FAIL R2 actual=%b expected=1", out_valid); end

    // R6: slider absent from occ still blocks
    occ_in = 64'h0; slide_in = 64'h0000_0000_0000_0009;
    @(negedge clk);
    check_out("R6 slider blocks", 64'h0000_0000_0000_00FE, 64'h0000_0000_0000_0007);

    // R8: plane-derived sliders, slide_in ignored
    seed = 64'h9E37_79B9_7F4A_7C15;
    pend = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (pend) check_out("R8 planes", pe, pw);
      for (int k = 0; k < 4; k++) begin
        seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
        planes_in[k*64 +: 64] = seed & (seed >> 3) & (seed >> 5);
      end
      seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
      occ_in = seed & (seed >> 2);
      slide_in = ~seed;
      src_sel = 1'b1;
      for (int q = 0; q < 64; q++)
        s[q] = planes_in[q*4] | planes_in[q*4+1] | planes_in[q*4+2] | planes_in[q*4+3];
      pe = walk(occ_in, s, 1'b0); pw = walk(occ_in, s, 1'b1); pend = 1'b1;
      @(negedge clk);
    end
    check_out("R8 planes", pe, pw);

    // R1: reset clears again
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || att_all !== '0) begin
      failures++;
      $display("FAIL R1 actual v=%b a=%h expected v=0 a=0", out_valid, att_all);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule